// File: doc/BRIEF.md
# Chip-Select Memory Controller

This block is a target on a simple internal request/acknowledge bus. When a request lands in its single address bank, it runs one access on an external asynchronous memory device. It drives the chip-select, output-enable and write-enable strobes, presents the latched address and write data, and returns a one-cycle transfer acknowledge to the master. It also returns read data in that acknowledge cycle and keeps it available afterwards.

Completion is chosen per access from a small timing register. In programmed-length mode the access lasts a configured number of bus clocks, and the acknowledge comes in the last of them. The controller never senses whether the device is ready, so the configured length must cover the device's access time. In external-termination mode the device's acknowledge input ends the access. A watchdog ends the access with an error if that input never arrives.

Writes may drop chip select one clock early. Reads hold chip select and output enable to the final cycle. One strobe-free clock separates consecutive accesses so the device can recover.

Top module: `csmc_top`

## Requirements
- R1: After reset, all three strobes (`mem_cs_n`, `mem_oe_n`, `mem_we_n`) are high and `req_ack` and `req_err` are low. The timing register resets to programmed-length mode, 16 clocks, no early negation. The bank base resets to 0.
- R2: A `cfg_wr` with `cfg_sel`=1 loads the timing register from `cfg_wdata`: bits [3:0] hold the length code L, bit 4 selects external termination, and bit 5 selects early chip-select negation. In programmed-length mode an accepted request holds `mem_cs_n` low for L+1 clocks, starting the clock after acceptance, and `req_ack` is high only in the last of those clocks.
- R3: On a read, `mem_oe_n` goes low in the second access clock, one clock after chip select, and stays low through the last clock. A one-clock read never asserts output enable.
- R4: On a read, chip select and output enable are both still low in the acknowledge clock and both go high in the clock after it.
- R5: On a write, `mem_we_n` is low in every clock that `mem_cs_n` is low, and `mem_oe_n` stays high.
- R6: When bit 5 is set, a write in programmed-length mode whose length is at least 2 clocks has `mem_cs_n` and `mem_we_n` high in its final (acknowledge) clock. The bit has no effect on reads or on external-termination accesses.
- R7: In external-termination mode, `req_ack` is high in the same clock in which `mem_ext_ack` is high during an access, and the length code is ignored.
- R8: In external-termination mode, if `mem_ext_ack` has not arrived by the 256th access clock (`WDOG_CLKS`), that clock carries `req_ack` together with `req_err`. If `mem_ext_ack` arrives in that same clock, `req_err` stays low.
- R9: In the acknowledge clock of a read, `req_rdata` equals `mem_rdata`. Afterwards it holds that captured value while `mem_rdata` changes.
- R10: The clock after any acknowledge has all strobes high and no acknowledge. A request held through that clock starts its next access, with chip select low, in the clock after it.
- R11: A `cfg_wr` with `cfg_sel`=0 loads the bank base from `cfg_wdata[3:0]`. A request whose `req_addr[15:12]` differs from the base is ignored: no strobe and no acknowledge.
- R12: While chip select is low, `mem_addr` equals the request address and, on writes, `mem_wdata` equals the request write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects bank base, 1 selects timing register |
| cfg_wdata | input | 6 | Configuration write data |
| req_valid | input | 1 | Request present, held until acknowledge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 16 | Request write data |
| req_ack | output | 1 | Transfer acknowledge, one clock |
| req_err | output | 1 | Access ended by watchdog, valid with `req_ack` |
| req_rdata | output | 16 | Read data to the master |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 16 | Address to the device |
| mem_wdata | output | 16 | Write data to the device |
| mem_rdata | input | 16 | Read data from the device |
| mem_ext_ack | input | 1 | External termination from the device, active high |

## Verification
The watchdog expiry and the device's external acknowledge can fall in the same clock. The bench provokes this by raising `mem_ext_ack` in exactly the 256th access clock. The acknowledge must appear once, in that clock, with `req_err` low. A second pair shares a clock on the write path: early chip-select negation and the acknowledge. For that case the bench samples the strobes in the acknowledge clock itself and expects chip select and write enable already high.

// File: rtl/csmc_pkg.sv
// Shared types for the chip-select memory controller.
// Assumes a single bank and one outstanding access at a time.
package csmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_RECOV  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic       early_cs;   // drop CS/WE one clock early on writes
        logic       ext_term;   // end access on device acknowledge
        logic [3:0] len_code;   // access length minus one
    } timing_cfg_t;

    localparam int CFG_W = 6;

endpackage

// File: rtl/csmc_regs.sv
// Configuration registers and bank decode.
// Holds the bank base and timing register, written through a simple
// strobe interface, and compares the upper address bits with the base.
// Assumes MATCH_W <= CFG_W.
module csmc_regs
    import csmc_pkg::*;
#(
    parameter int MATCH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [MATCH_W-1:0] addr_hi,
    output timing_cfg_t        timing,
    output logic               hit
);

    logic [MATCH_W-1:0] base_q;

    // Register writes; timing defaults to the slowest programmed length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            timing <= '{early_cs: 1'b0, ext_term: 1'b0, len_code: 4'hF};
        end else if (cfg_wr) begin
            if (cfg_sel) timing <= timing_cfg_t'(cfg_wdata);
            else         base_q <= cfg_wdata[MATCH_W-1:0];
        end
    end

    // Bank match on the upper address bits.
    always_comb hit = (addr_hi == base_q);

endmodule

// File: rtl/csmc_seq.sv
// Access sequencer: accepts a request, counts access clocks, drives the
// strobes and produces the acknowledge and watchdog error.
// Assumes the master holds its request until acknowledged. Timing is
// latched at acceptance, so register writes mid-access do not disturb it.
module csmc_seq
    import csmc_pkg::*;
#(
    parameter int WDOG_CLKS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        req_write,
    input  timing_cfg_t timing,
    input  logic        mem_ext_ack,
    output logic        accept,
    output logic        done,
    output logic        err,
    output logic        rd_cycle,
    output logic        cs_n,
    output logic        oe_n,
    output logic        we_n
);

    localparam int SPAN = (WDOG_CLKS > 16) ? WDOG_CLKS : 16;
    localparam int CW   = $clog2(SPAN);

    seq_state_t  state;
    logic [CW-1:0] cnt;
    logic        wr_q;
    timing_cfg_t tcfg_q;
    logic        in_access;
    logic        last_norm;
    logic        wdog_end;
    logic        early_drop;

    // Decode of the current access clock.
    always_comb begin
        in_access  = (state == ST_ACCESS);
        last_norm  = (cnt == CW'(tcfg_q.len_code));
        wdog_end   = (cnt == CW'(WDOG_CLKS - 1));
        accept     = start && ((state == ST_IDLE) || (state == ST_RECOV));
        done       = in_access && (tcfg_q.ext_term ? (mem_ext_ack || wdog_end) : last_norm);
        err        = in_access && tcfg_q.ext_term && !mem_ext_ack && wdog_end;
        early_drop = in_access && wr_q && tcfg_q.early_cs && !tcfg_q.ext_term
                     && last_norm && (tcfg_q.len_code != 4'd0);
        rd_cycle   = in_access && !wr_q;
    end

    // Strobe generation from the sequencer state.
    always_comb begin
        cs_n = !(in_access && !early_drop);
        we_n = !(in_access && wr_q && !early_drop);
        oe_n = !(in_access && !wr_q && (cnt != '0));
    end

    // State, clock counter and per-access latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            wr_q   <= 1'b0;
            tcfg_q <= '{early_cs: 1'b0, ext_term: 1'b0, len_code: 4'hF};
        end else begin
            case (state)
                ST_IDLE, ST_RECOV: begin
                    if (accept) begin
                        state  <= ST_ACCESS;
                        cnt    <= '0;
                        wr_q   <= req_write;
                        tcfg_q <= timing;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_ACCESS: begin
                    if (done) state <= ST_RECOV;
                    else      cnt   <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/csmc_datapath.sv
// Address, write-data and read-data latches between bus and device.
// Read data passes straight through in the acknowledge clock and is
// captured at its end so the master sees a stable value afterwards.
module csmc_datapath #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          done,
    input  logic          rd_cycle,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] rdata_q;
    logic          rd_take;

    always_comb rd_take = done && rd_cycle;

    // Capture request fields at acceptance, read data at acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                mem_addr  <= req_addr;
                mem_wdata <= req_wdata;
            end
            if (rd_take) rdata_q <= mem_rdata;
        end
    end

    // Pass-through in the acknowledge clock, held value otherwise.
    always_comb rdata = rd_take ? mem_rdata : rdata_q;

endmodule

// File: rtl/csmc_top.sv
// Chip-select memory controller top: one bank, programmed-length or
// externally terminated accesses, watchdog, one recovery clock.
// Assumes a single master that holds req_valid until req_ack.
module csmc_top
    import csmc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int MATCH_W   = 4,
    parameter int WDOG_CLKS = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ack,
    output logic             req_err,
    output logic [DW-1:0]    req_rdata,
    output logic             mem_cs_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ext_ack
);

    timing_cfg_t timing;
    logic        hit;
    logic        start;
    logic        accept;
    logic        rd_cycle;

    always_comb start = req_valid && hit;

    csmc_regs #(.MATCH_W(MATCH_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .addr_hi   (req_addr[AW-1 -: MATCH_W]),
        .timing    (timing),
        .hit       (hit)
    );

    csmc_seq #(.WDOG_CLKS(WDOG_CLKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req_write   (req_write),
        .timing      (timing),
        .mem_ext_ack (mem_ext_ack),
        .accept      (accept),
        .done        (req_ack),
        .err         (req_err),
        .rd_cycle    (rd_cycle),
        .cs_n        (mem_cs_n),
        .oe_n        (mem_oe_n),
        .we_n        (mem_we_n)
    );

    csmc_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .done      (req_ack),
        .rd_cycle  (rd_cycle),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rdata     (req_rdata)
    );

endmodule

// File: rtl/csmc_chk.sv
// Protocol checker for csmc_top, attached by bind.
module csmc_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ack,
    input logic req_err,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n
);

    // R5
    no_oe_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe_n || mem_we_n));

    // R8
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_ack);

    // R10
    recov_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> (mem_cs_n && mem_oe_n && mem_we_n && !req_ack));

    // R3
    oe_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(mem_cs_n) == 1'b0));

    // R4
    no_oe_without_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe_n || !mem_cs_n));

    // R11
    cs_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> $past(req_valid));

endmodule

bind csmc_top csmc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_err   (req_err),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
);

// File: tb/sim_csmc_top.sv
// Directed bench for csmc_top: one task per scenario.
module sim_csmc_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic        cfg_sel;
    logic [5:0]  cfg_wdata;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic [15:0] req_wdata;
    logic        req_ack;
    logic        req_err;
    logic [15:0] req_rdata;
    logic        mem_cs_n;
    logic        mem_oe_n;
    logic        mem_we_n;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_ext_ack;

    int n_checks = 0;
    int n_err    = 0;

    always #5 clk = ~clk;

    // Device model: drives a pattern only while output enable is low.
    assign mem_rdata = mem_oe_n ? 16'h0000 : (mem_addr ^ 16'hA5A5);

    csmc_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ack     (req_ack),
        .req_err     (req_err),
        .req_rdata   (req_rdata),
        .mem_cs_n    (mem_cs_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ext_ack (mem_ext_ack)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    task automatic cfg_write(input bit sel, input logic [5:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // One access; checks strobes every clock, acknowledge position,
    // error, read data and the recovery clock.
    task automatic access(input bit wr, input logic [15:0] addr,
                          input logic [15:0] wd, input int exp_cyc,
                          input int ext_at, input bit exp_err,
                          input bit early_eff, input string tag);
        int          bad = 0;
        int          seen = -1;
        logic [15:0] rd_ack = '0;
        bit          err_ack = 1'b0;
        bit          e_cs, e_oe, e_we, last;
        logic [15:0] exp_rd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        for (int i = 0; i < exp_cyc + 2; i++) begin
            @(negedge clk);
            mem_ext_ack = (i == ext_at);
            #1;
            last = (i == exp_cyc - 1);
            e_cs = !(wr && early_eff && exp_cyc >= 2 && last);
            e_oe = !wr && (i >= 1);
            e_we = wr && e_cs;
            if (mem_cs_n != !e_cs || mem_oe_n != !e_oe || mem_we_n != !e_we) bad++;
            if (!mem_cs_n && (mem_addr != addr || (wr && mem_wdata != wd))) bad++;
            if (req_ack) begin
                seen    = i;
                rd_ack  = req_rdata;
                err_ack = req_err;
                break;
            end
        end
        @(negedge clk);
        req_valid = 1'b0; mem_ext_ack = 1'b0;
        #1;
        check(seen == exp_cyc - 1, tag, "ack clock index", seen, exp_cyc - 1);
        check(bad == 0, tag, "strobe/address mismatches (R12)", bad, 0);
        check(err_ack == exp_err, tag, "error flag", err_ack, exp_err);
        check(mem_cs_n && mem_oe_n && mem_we_n && !req_ack, "R10",
              "recovery clock strobes", {mem_cs_n, mem_oe_n, mem_we_n, req_ack}, 4'b1110);
        if (!wr) begin
            exp_rd = (exp_cyc >= 2) ? (addr ^ 16'hA5A5) : 16'h0000;
            check(rd_ack == exp_rd, "R9", "read data in ack clock", rd_ack, exp_rd);
            check(req_rdata == exp_rd, "R9", "read data held after ack", req_rdata, exp_rd);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        mem_ext_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(mem_cs_n && mem_oe_n && mem_we_n && !req_ack && !req_err, "R1",
              "reset outputs", {mem_cs_n, mem_oe_n, mem_we_n, req_ack, req_err}, 5'b11100);
        // R1: default timing is 16 clocks, programmed length, base 0
        access(1'b0, 16'h0042, 16'h0, 16, -1, 1'b0, 1'b0, "R1 R2 R3");
    endtask

    task automatic t_normal;
        cfg_write(1'b1, 6'h03);
        access(1'b0, 16'h0010, 16'h0, 4, -1, 1'b0, 1'b0, "R2 R3 R4");
        cfg_write(1'b1, 6'h00);
        access(1'b0, 16'h0123, 16'h0, 1, -1, 1'b0, 1'b0, "R2 R3");
        cfg_write(1'b1, 6'h0F);
        access(1'b0, 16'h0FFE, 16'h0, 16, -1, 1'b0, 1'b0, "R2 R4");
        cfg_write(1'b1, 6'h03);
        access(1'b1, 16'h0200, 16'hBEEF, 4, -1, 1'b0, 1'b0, "R5 R12");
    endtask

    task automatic t_early;
        cfg_write(1'b1, 6'h23);
        access(1'b1, 16'h0300, 16'h1234, 4, -1, 1'b0, 1'b1, "R6");
        access(1'b0, 16'h0301, 16'h0, 4, -1, 1'b0, 1'b0, "R6 read");
        cfg_write(1'b1, 6'h20);
        access(1'b1, 16'h0302, 16'h5678, 1, -1, 1'b0, 1'b1, "R6 len1");
    endtask

    task automatic t_ext;
        cfg_write(1'b1, 6'h13);
        access(1'b0, 16'h0400, 16'h0, 7, 6, 1'b0, 1'b0, "R7");
        cfg_write(1'b1, 6'h33);
        access(1'b1, 16'h0401, 16'h9ABC, 3, 2, 1'b0, 1'b0, "R7 R6");
    endtask

    task automatic t_watchdog;
        cfg_write(1'b1, 6'h10);
        access(1'b0, 16'h0500, 16'h0, 256, -1, 1'b1, 1'b0, "R8 expiry");
        access(1'b0, 16'h0501, 16'h0, 256, 255, 1'b0, 1'b0, "R8 same clock");
    endtask

    task automatic t_recovery;
        int n = 0;
        cfg_write(1'b1, 6'h01);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0600;
        while (n < 10) begin
            @(negedge clk); #1; n++;
            if (req_ack) break;
        end
        check(n == 2, "R10", "first ack clock", n, 2);
        @(negedge clk); #1;
        check(mem_cs_n && !req_ack, "R10", "gap clock strobe-free", {mem_cs_n, req_ack}, 2'b10);
        @(negedge clk); #1;
        check(!mem_cs_n, "R10", "held request restarts after one clock", mem_cs_n, 0);
        @(negedge clk); #1;
        check(req_ack, "R10", "second access ack", req_ack, 1);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_miss;
        int bad = 0;
        cfg_write(1'b0, 6'h03);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h1234; req_wdata = 16'h1111;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            if (!mem_cs_n || !mem_we_n || req_ack) bad++;
        end
        req_valid = 1'b0;
        check(bad == 0, "R11", "miss produced strobes or ack", bad, 0);
        access(1'b0, 16'h3456, 16'h0, 2, -1, 1'b0, 1'b0, "R11 hit");
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "WDOG", "bench watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        t_reset();
        t_normal();
        t_early();
        t_ext();
        t_watchdog();
        t_recovery();
        t_miss();
        finish_run();
    end

endmodule